// File: doc/BRIEF.md
# Serial Lane Power-Down Gating Controller

This block decides, for each serial link lane of a multi-function network controller, whether the lane may be switched off or must stay running. Each lane belongs to one LAN function and is judged only from that function's own conditions: its device power state, whether wake-on-LAN is armed, whether pass-through management traffic uses the lane, whether power-management events are enabled, whether the function is strapped to PHY mode, and the level of its LAN-disable pin. Two configuration bits shape the decision. A global low-power enable must be set before any lane can turn off. A second bit selects whether the LAN-disable pin is allowed to turn the lane off; it is clear by default, because management traffic may still need the lane.

For every lane the block registers a power-down request and a 2-bit reason code. The reason code tells which path caused the request, so that power-management firmware or a neighbouring sequencer can tell a PHY-mode shutdown from a quiet low-power state. All inputs are taken to be synchronous levels already. A change in any input shows up on the outputs at the next rising clock edge, so a lane whose qualifying condition goes away is powered again one clock later.

Top module: `serdes_lp_gate`

## Requirements
- R1: While the synchronous active-low reset is sampled low, every lane's power-down request is 0 and its reason code is 00.
- R2: When the global low-power enable is 0, every lane reports power-down 0 and reason 00, whatever its other inputs are.
- R3: With the enable set, a lane whose device state is not D0 (state code 0 means D0; any nonzero code means a lower state), with wake-on-LAN off, pass-through management off and PME disabled, is powered down with reason 01.
- R4: If any one of those four conditions is not met (state is D0, wake armed, management on or PME enabled), the low-power-state path does not power the lane down.
- R5: With the enable set, a lane in PHY mode is powered down with reason 10. This path takes priority over the other two.
- R6: With the enable set and the power-down-on-disable bit set, an asserted LAN-disable pin powers the lane down with reason 11. This beats the low-power-state path but loses to PHY mode.
- R7: When the power-down-on-disable bit is 0, the LAN-disable pin has no effect: the lane's request and reason are the same as with the pin low.
- R8: Each lane is judged only from its own function's inputs. The inputs of one lane never change another lane's outputs.
- R9: The outputs are registered. They reflect the inputs sampled at the previous rising edge and stay steady between edges, so a lane whose condition drops is powered again at the next edge.
- R10: A lane's power-down request is 1 exactly when its reason code is not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_lp_en | input | 1 | Global low-power enable |
| cfg_pd_on_dis | input | 1 | Allows LAN-disable pin to power the lane down |
| fn_dstate | input | NUM_LANES*DST_W | Per-lane device power state, 0 = D0 |
| fn_wol | input | NUM_LANES | Per-lane wake-on-LAN active |
| fn_mng_pt | input | NUM_LANES | Per-lane pass-through management enabled |
| fn_pme_en | input | NUM_LANES | Per-lane PME enabled |
| fn_phy_mode | input | NUM_LANES | Per-lane PHY mode selected |
| lan_dis | input | NUM_LANES | Per-lane LAN-disable pin level |
| pd_req_o | output | NUM_LANES | Registered per-lane power-down request |
| pd_reason_o | output | 2*NUM_LANES | Registered per-lane reason: 00 on, 01 low-power state, 10 PHY mode, 11 LAN disable |

## Verification
PHY mode, the enabled LAN-disable pin and the full low-power-state qualification can all be true for the same lane in the same cycle. The reason code must then follow the fixed priority. The bench drives directed cycles where all three paths hold together, and cycles where only the lower two hold. It also biases its random stimulus so that such overlaps are frequent. A reference function that applies the priority decides the expected code for each lane on every cycle, and the code sampled after the next edge is compared against it.

// File: rtl/serdes_lp_pkg.sv
package serdes_lp_pkg;

    typedef enum logic [1:0] {
        RSN_ON  = 2'b00,
        RSN_LPS = 2'b01,
        RSN_PHY = 2'b10,
        RSN_DIS = 2'b11
    } lp_reason_e;

endpackage

// File: rtl/lp_lane_eval.sv
module lp_lane_eval #(
    parameter int DST_W = 2
) (
    input  logic [DST_W-1:0] dstate,
    input  logic             wol,
    input  logic             mng_pt,
    input  logic             pme_en,
    input  logic             phy_mode,
    input  logic             lan_dis,
    input  logic             cfg_pd_on_dis,
    output logic             lps_hit,
    output logic             phy_hit,
    output logic             dis_hit
);
    localparam logic [DST_W-1:0] D0_CODE = '0;

    always_comb begin
        // all four quiet conditions must hold together
        lps_hit = (dstate != D0_CODE) && !wol && !mng_pt && !pme_en;
        phy_hit = phy_mode;
        // pin only counts when configuration allows it
        dis_hit = lan_dis && cfg_pd_on_dis;
    end
endmodule

// File: rtl/lp_reason_prio.sv
module lp_reason_prio
    import serdes_lp_pkg::*;
(
    input  logic       lp_en,
    input  logic       lps_hit,
    input  logic       phy_hit,
    input  logic       dis_hit,
    output lp_reason_e reason
);
    always_comb begin
        if (!lp_en)       reason = RSN_ON;
        else if (phy_hit) reason = RSN_PHY;
        else if (dis_hit) reason = RSN_DIS;
        else if (lps_hit) reason = RSN_LPS;
        else              reason = RSN_ON;
    end
endmodule

// File: rtl/serdes_lp_gate.sv
module serdes_lp_gate
    import serdes_lp_pkg::*;
#(
    parameter int NUM_LANES = 2,
    parameter int DST_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_lp_en,
    input  logic                       cfg_pd_on_dis,
    input  logic [NUM_LANES*DST_W-1:0] fn_dstate,
    input  logic [NUM_LANES-1:0]       fn_wol,
    input  logic [NUM_LANES-1:0]       fn_mng_pt,
    input  logic [NUM_LANES-1:0]       fn_pme_en,
    input  logic [NUM_LANES-1:0]       fn_phy_mode,
    input  logic [NUM_LANES-1:0]       lan_dis,
    output logic [NUM_LANES-1:0]       pd_req_o,
    output logic [2*NUM_LANES-1:0]     pd_reason_o
);
    localparam int RSN_W = $bits(lp_reason_e);

    typedef struct packed {
        logic [NUM_LANES-1:0]            pd;
        logic [NUM_LANES-1:0][RSN_W-1:0] rsn;
    } gate_st_t;

    gate_st_t   st_d, st_q;
    lp_reason_e rsn_nxt [NUM_LANES];

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic lps_hit, phy_hit, dis_hit;

        lp_lane_eval #(.DST_W(DST_W)) u_eval (
            .dstate        (fn_dstate[i*DST_W +: DST_W]),
            .wol           (fn_wol[i]),
            .mng_pt        (fn_mng_pt[i]),
            .pme_en        (fn_pme_en[i]),
            .phy_mode      (fn_phy_mode[i]),
            .lan_dis       (lan_dis[i]),
            .cfg_pd_on_dis (cfg_pd_on_dis),
            .lps_hit       (lps_hit),
            .phy_hit       (phy_hit),
            .dis_hit       (dis_hit)
        );

        lp_reason_prio u_prio (
            .lp_en   (cfg_lp_en),
            .lps_hit (lps_hit),
            .phy_hit (phy_hit),
            .dis_hit (dis_hit),
            .reason  (rsn_nxt[i])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_LANES; i++) begin
            st_d.rsn[i] = rsn_nxt[i];
            st_d.pd[i]  = (rsn_nxt[i] != RSN_ON);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        pd_req_o = st_q.pd;
        for (int i = 0; i < NUM_LANES; i++) begin
            pd_reason_o[i*RSN_W +: RSN_W] = st_q.rsn[i];
        end
    end
endmodule

// File: rtl/serdes_lp_gate_chk.sv
module serdes_lp_gate_chk #(
    parameter int NUM_LANES = 2,
    parameter int DST_W     = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_lp_en,
    input logic                       cfg_pd_on_dis,
    input logic [NUM_LANES*DST_W-1:0] fn_dstate,
    input logic [NUM_LANES-1:0]       fn_wol,
    input logic [NUM_LANES-1:0]       fn_mng_pt,
    input logic [NUM_LANES-1:0]       fn_pme_en,
    input logic [NUM_LANES-1:0]       fn_phy_mode,
    input logic [NUM_LANES-1:0]       lan_dis,
    input logic [NUM_LANES-1:0]       pd_req_o,
    input logic [2*NUM_LANES-1:0]     pd_reason_o
);
    logic hist_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) hist_ok <= 1'b0;
        else        hist_ok <= 1'b1;
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_chk
        AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
            !$past(cfg_lp_en) |-> !pd_req_o[i]); // R2
        AST_LPS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
            (pd_reason_o[2*i +: 2] == 2'b01) |->
            $past((fn_dstate[i*DST_W +: DST_W] != '0) && !fn_wol[i] && !fn_mng_pt[i] && !fn_pme_en[i])); // R4
        AST_PHY_FIRST: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
            $past(cfg_lp_en && fn_phy_mode[i]) |-> (pd_reason_o[2*i +: 2] == 2'b10)); // R5
        AST_DIS_MASKED: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
            !$past(cfg_pd_on_dis) |-> (pd_reason_o[2*i +: 2] != 2'b11)); // R7
        AST_WAKE_POWERS_UP: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
            $past(fn_wol[i] && !fn_phy_mode[i] && !(lan_dis[i] && cfg_pd_on_dis)) |-> !pd_req_o[i]); // R9
        AST_REQ_MATCHES_REASON: assert property (@(posedge clk) disable iff (!rst_n)
            pd_req_o[i] == (pd_reason_o[2*i +: 2] != 2'b00)); // R10
    end
endmodule

bind serdes_lp_gate serdes_lp_gate_chk #(.NUM_LANES(NUM_LANES), .DST_W(DST_W)) u_chk (.*);

// File: tb/serdes_lp_gate_tb_top.sv
module serdes_lp_gate_tb_top;
    localparam int N  = 2;
    localparam int DW = 2;
    localparam time CLK_P = 4ns;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_lp_en, cfg_pd_on_dis;
    logic [N*DW-1:0] fn_dstate;
    logic [N-1:0]  fn_wol, fn_mng_pt, fn_pme_en, fn_phy_mode, lan_dis;
    logic [N-1:0]  pd_req_o;
    logic [2*N-1:0] pd_reason_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    serdes_lp_gate #(.NUM_LANES(N), .DST_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_lp_en(cfg_lp_en), .cfg_pd_on_dis(cfg_pd_on_dis),
        .fn_dstate(fn_dstate), .fn_wol(fn_wol), .fn_mng_pt(fn_mng_pt), .fn_pme_en(fn_pme_en),
        .fn_phy_mode(fn_phy_mode), .lan_dis(lan_dis), .pd_req_o(pd_req_o), .pd_reason_o(pd_reason_o)
    );

    // reference: priority PHY > enabled disable pin > quiet low-power state
    function automatic logic [1:0] ref_rsn(int l);
        logic quiet;
        quiet = (fn_dstate[l*DW +: DW] != 0) && !fn_wol[l] && !fn_mng_pt[l] && !fn_pme_en[l];
        if (!cfg_lp_en)                        return 2'b00;
        if (fn_phy_mode[l])                    return 2'b10;
        if (lan_dis[l] && cfg_pd_on_dis)       return 2'b11;
        if (quiet)                             return 2'b01;
        return 2'b00;
    endfunction

    task automatic cmp(string tag, int l, logic [1:0] exp);
        n_chk++;
        if (pd_reason_o[2*l +: 2] !== exp) begin
            n_fail++;
            $display("FAIL %s lane%0d reason actual=%b expected=%b", tag, l, pd_reason_o[2*l +: 2], exp);
        end
        n_chk++;
        if (pd_req_o[l] !== (exp != 2'b00)) begin
            n_fail++;
            $display("FAIL R10 lane%0d pd actual=%b expected=%b", l, pd_req_o[l], exp != 2'b00);
        end
    endtask

    // compute expectations, clock once, sample 1ns after the edge
    task automatic step_check(string t0, string t1);
        logic [1:0] e0, e1;
        e0 = ref_rsn(0);
        e1 = ref_rsn(1);
        @(posedge clk); #1ns;
        cmp(t0, 0, e0);
        cmp(t1, 1, e1);
    endtask

    task automatic quiet_lane(int l);
        fn_dstate[l*DW +: DW] = 2'd3;
        fn_wol[l] = 0; fn_mng_pt[l] = 0; fn_pme_en[l] = 0;
        fn_phy_mode[l] = 0; lan_dis[l] = 0;
    endtask

    task automatic busy_lane(int l);
        fn_dstate[l*DW +: DW] = 2'd0;
        fn_wol[l] = 0; fn_mng_pt[l] = 0; fn_pme_en[l] = 0;
        fn_phy_mode[l] = 0; lan_dis[l] = 0;
    endtask

    function automatic string tag_of(int l);
        logic [1:0] e;
        e = ref_rsn(l);
        if (e == 2'b10) return "R5";
        if (e == 2'b11) return "R6";
        if (e == 2'b01) return "R3";
        if (!cfg_lp_en) return "R2";
        if (lan_dis[l]) return "R7";
        return "R4";
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [1:0] hold0;
        void'($urandom(32'h5EED_0042));
        rst_n = 0; cfg_lp_en = 1; cfg_pd_on_dis = 1;
        quiet_lane(0); quiet_lane(1);
        fn_phy_mode = '1;
        repeat (3) @(posedge clk);
        #1ns;
        cmp("R1", 0, 2'b00);
        cmp("R1", 1, 2'b00);
        rst_n = 1;

        // R2: global enable off masks every path
        cfg_lp_en = 0; lan_dis = '1;
        step_check("R2", "R2");

        // R3 on lane0, R8 lane1 kept in D0 stays up
        cfg_lp_en = 1; quiet_lane(0); busy_lane(1);
        step_check("R3", "R8");

        // R4: break each quiet condition in turn
        for (int k = 0; k < 4; k++) begin
            quiet_lane(0);
            case (k)
                0: fn_dstate[1:0] = 2'd0;
                1: fn_wol[0] = 1;
                2: fn_mng_pt[0] = 1;
                default: fn_pme_en[0] = 1;
            endcase
            step_check("R4", "R8");
        end

        // R5: all three paths at once, PHY wins; lane1 independent (R8)
        quiet_lane(0); fn_phy_mode[0] = 1; lan_dis[0] = 1; cfg_pd_on_dis = 1;
        quiet_lane(1);
        step_check("R5", "R8");

        // R6: disable pin beats low-power state
        fn_phy_mode[0] = 0;
        step_check("R6", "R3");

        // R7: pin ignored when configuration bit clear
        cfg_pd_on_dis = 0;
        step_check("R7", "R3");
        busy_lane(0); lan_dis[0] = 1;
        step_check("R7", "R3");

        // R9: output steady between edges, then powers up at next edge
        quiet_lane(0);
        step_check("R3", "R3");
        fn_wol[0] = 1;
        hold0 = pd_reason_o[1:0];
        #1ns;
        n_chk++;
        if (pd_reason_o[1:0] !== hold0 || hold0 !== 2'b01) begin
            n_fail++;
            $display("FAIL R9 lane0 pre-edge actual=%b expected=%b", pd_reason_o[1:0], 2'b01);
        end
        step_check("R9", "R3");

        // random mix with biases toward overlaps
        for (int it = 0; it < 600; it++) begin
            cfg_lp_en     = ($urandom_range(0, 9) != 0);
            cfg_pd_on_dis = $urandom_range(0, 1);
            for (int l = 0; l < N; l++) begin
                fn_dstate[l*DW +: DW] = ($urandom_range(0, 3) == 0) ? 2'd0 : DW'($urandom_range(1, 3));
                fn_wol[l]      = ($urandom_range(0, 4) == 0);
                fn_mng_pt[l]   = ($urandom_range(0, 4) == 0);
                fn_pme_en[l]   = ($urandom_range(0, 4) == 0);
                fn_phy_mode[l] = ($urandom_range(0, 4) == 0);
                lan_dis[l]     = ($urandom_range(0, 2) == 0);
            end
            step_check(tag_of(0), tag_of(1));
        end

        done = 1;
        summary();
        $finish;
    end
endmodule